// File: doc/BRIEF.md
# Backward Branch Frequency Profiler

This block sits beside a processor's instruction memory bus and only listens. Each time a fetch is reported, it compares the address with the address of the fetch before it. When the new address is strictly lower, the fetch is the target of a backward branch, which usually means a loop has closed. Such targets are kept in a small fully associative table. Each table slot holds the target address, a valid flag and a saturating-free frequency counter. The profiler has no output that reaches the bus, so it can never stall or change the program being watched.

The counters measure relative frequency. When a counter that is already at its maximum is hit again, every counter in the table is halved in that same cycle, and then the hit slot is incremented. This keeps the ranking of the loops while the run goes on for as long as it needs to. When a new target arrives and no slot is free, the slot with the lowest count is given to it.

A read port returns any one slot. A registered index names the slot that currently holds the largest count, so a later analysis step can find the hottest loop. A synchronous clear empties the table.

Top module: `bbp_profiler`

## Requirements
- R1: A fetch is a backward branch only when `fetch_valid` is 1, an earlier valid fetch has been recorded since reset or clear, and `fetch_addr` is strictly lower than the address of that last valid fetch. Equal or higher addresses change nothing. Cycles with `fetch_valid` at 0 neither count nor update the recorded address.
- R2: A backward-branch target that is not in the table takes the free slot with the lowest index. That slot becomes valid, stores the target as its tag and sets its count to 1.
- R3: A backward-branch target that matches a valid tag adds 1 to that slot's count. A target occupies at most one slot.
- R4: When the matching slot's count is 255, every count in the table is shifted right by one bit in the same cycle, and the matching slot then ends at 128.
- R5: A new target that arrives while all 16 slots are valid replaces the slot with the smallest count, choosing the lowest index on a tie. The replaced slot takes the new tag with a count of 1.
- R6: `hot_idx` is registered. One clock after any count change, it shows the index of the largest count, choosing the lowest index on a tie. It shows 0 when all counts are 0.
- R7: While `clear` is 1 at a clock edge, all slots become invalid, all counts become 0 and the recorded previous address is forgotten. A fetch presented in the same cycle is ignored.
- R8: `rd_tag`, `rd_count` and `rd_valid` show the slot selected by `rd_idx` combinationally, without added latency.
- R9: After reset, every slot is invalid with a count of 0 and `hot_idx` is 0.
- R10: Under a steady mix in which one loop target is hit four times as often as another, `hot_idx` still names the more frequent target after at least 10 rescaling events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous table clear |
| fetch_valid | input | 1 | Bus fetch strobe |
| fetch_addr | input | 32 | Fetch address seen on the bus |
| rd_idx | input | 4 | Slot selected for reading |
| rd_tag | output | 32 | Tag of the selected slot |
| rd_count | output | 8 | Count of the selected slot |
| rd_valid | output | 1 | Valid flag of the selected slot |
| hot_idx | output | 4 | Registered index of the largest count |

## Verification
A fetch that is driven before a clock edge updates the table at that edge. The read port is combinational, so the slot contents can be read in the low phase that follows. `hot_idx` is computed from the counts after that edge and registered, so it is correct one edge later. The driver therefore moves on by one more rising edge before it queues a hot-index expectation. The monitor compares every queued item at the falling edge after it was queued, while `rd_idx` is held steady, and the driver waits until the queue is empty before it changes `rd_idx` again.

// File: rtl/bbp_pkg.sv
package bbp_pkg;

  // What the table does on a given cycle
  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_BUMP,
    ACT_BUMP_RESCALE,
    ACT_ALLOC
  } bbp_act_e;

endpackage

// File: rtl/bbp_tag_match.sv
module bbp_tag_match #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]   tags,
  input  logic [ENTRIES-1:0]               valids,
  input  logic [ADDR_W-1:0]                key,
  output logic                             hit,
  output logic [IDX_W-1:0]                 hit_idx,
  output logic                             has_free,
  output logic [IDX_W-1:0]                 free_idx
);

  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valids[g] && (tags[g] == key);
  end

  assign hit      = |match;
  assign has_free = ~&valids;

  // Lowest set index wins in both encoders
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])   hit_idx  = IDX_W'(i);
      if (!valids[i]) free_idx = IDX_W'(i);
    end
  end

  // R3: a target never lives in two slots
  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/bbp_rank.sv
module bbp_rank #(
  parameter int ENTRIES  = 16,
  parameter int CNT_W    = 8,
  parameter int IDX_W    = $clog2(ENTRIES),
  parameter bit FIND_MAX = 1'b1
) (
  input  logic [ENTRIES-1:0][CNT_W-1:0] counts,
  output logic [IDX_W-1:0]              sel_idx
);

  if (FIND_MAX) begin : g_max
    logic [CNT_W-1:0] best;
    always_comb begin
      best    = counts[0];
      sel_idx = '0;
      for (int i = 1; i < ENTRIES; i++) begin
        if (counts[i] > best) begin
          best    = counts[i];
          sel_idx = IDX_W'(i);
        end
      end
    end
  end else begin : g_min
    logic [CNT_W-1:0] best;
    always_comb begin
      best    = counts[0];
      sel_idx = '0;
      for (int i = 1; i < ENTRIES; i++) begin
        if (counts[i] < best) begin
          best    = counts[i];
          sel_idx = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/bbp_profiler.sv
module bbp_profiler
  import bbp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_tag,
  output logic [CNT_W-1:0]  rd_count,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  hot_idx
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] RESCALED = (CNT_MAX >> 1) + CNT_ONE;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // State
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q, cnt_d;
  logic [ENTRIES-1:0]             val_q, val_d;
  logic [ADDR_W-1:0]              prev_q;
  logic                           have_q;
  logic [IDX_W-1:0]               hot_q;

  // Lookup and ranking
  logic             hit, has_free, is_back, table_en;
  logic [IDX_W-1:0] hit_idx, free_idx, min_idx, max_idx, victim;
  bbp_act_e         act;

  bbp_tag_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_sn),
    .tags     (tag_q),
    .valids   (val_q),
    .key      (fetch_addr),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .has_free (has_free),
    .free_idx (free_idx)
  );

  bbp_rank #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W), .FIND_MAX(1'b0)) u_min (
    .counts  (cnt_q),
    .sel_idx (min_idx)
  );

  bbp_rank #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W), .FIND_MAX(1'b1)) u_max (
    .counts  (cnt_q),
    .sel_idx (max_idx)
  );

  // Next-state
  assign is_back  = fetch_valid && have_q && !clear && (fetch_addr < prev_q);
  assign table_en = clear || is_back;
  assign victim   = has_free ? free_idx : min_idx;

  always_comb begin
    act = ACT_IDLE;
    if (is_back) begin
      if (!hit)                          act = ACT_ALLOC;
      else if (cnt_q[hit_idx] == CNT_MAX) act = ACT_BUMP_RESCALE;
      else                               act = ACT_BUMP;
    end
  end

  always_comb begin
    tag_d = tag_q;
    val_d = val_q;
    for (int i = 0; i < ENTRIES; i++) begin
      cnt_d[i] = (act == ACT_BUMP_RESCALE) ? (cnt_q[i] >> 1) : cnt_q[i];
    end
    if (act == ACT_BUMP || act == ACT_BUMP_RESCALE) begin
      cnt_d[hit_idx] = cnt_d[hit_idx] + CNT_ONE;
    end
    if (act == ACT_ALLOC) begin
      tag_d[victim] = fetch_addr;
      val_d[victim] = 1'b1;
      cnt_d[victim] = CNT_ONE;
    end
    if (clear) begin
      val_d = '0;
      cnt_d = '0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      tag_q <= '0;
      cnt_q <= '0;
      val_q <= '0;
    end else if (table_en) begin
      tag_q <= tag_d;
      cnt_q <= cnt_d;
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (clear) begin
      have_q <= 1'b0;
    end else if (fetch_valid) begin
      prev_q <= fetch_addr;
      have_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) hot_q <= '0;
    else         hot_q <= max_idx;
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_count = cnt_q[rd_idx];
  assign rd_valid = val_q[rd_idx];
  assign hot_idx  = hot_q;

  // Checks
  a_r1_no_fetch_no_change: assert property (@(posedge clk) disable iff (!rst_sn)
    (!fetch_valid && !clear) |=> ($stable(val_q) && $stable(cnt_q)));

  a_r2_alloc_slot: assert property (@(posedge clk) disable iff (!rst_sn)
    (act == ACT_ALLOC) |=> (val_q[$past(victim)] && cnt_q[$past(victim)] == CNT_ONE
                            && tag_q[$past(victim)] == $past(fetch_addr)));

  a_r3_bump_by_one: assert property (@(posedge clk) disable iff (!rst_sn)
    (act == ACT_BUMP) |=> (cnt_q[$past(hit_idx)] == $past(cnt_q[hit_idx]) + CNT_ONE));

  a_r4_rescale_value: assert property (@(posedge clk) disable iff (!rst_sn)
    (act == ACT_BUMP_RESCALE) |=> (cnt_q[$past(hit_idx)] == RESCALED));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_sn)
    clear |=> (val_q == '0 && cnt_q == '0 && !have_q));

  // R6: hot index never points below any count of the prior cycle
  logic [ENTRIES-1:0][CNT_W-1:0] seen_cnt;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) seen_cnt <= '0;
    else         seen_cnt <= cnt_q;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_hot_chk
    a_r6_hot_is_max: assert property (@(posedge clk) disable iff (!rst_sn)
      seen_cnt[g] <= seen_cnt[hot_q]);
  end

endmodule

// File: tb/bbp_profiler_test.sv
module bbp_profiler_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic [3:0]  rd_idx;
  logic [31:0] rd_tag;
  logic [7:0]  rd_count;
  logic        rd_valid;
  logic [3:0]  hot_idx;

  always #5 clk = ~clk;

  bbp_profiler uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .rd_idx      (rd_idx),
    .rd_tag      (rd_tag),
    .rd_count    (rd_count),
    .rd_valid    (rd_valid),
    .hot_idx     (hot_idx)
  );

  localparam logic [31:0] HIGH = 32'h0000_FFF0;

  int total = 0;
  int bad   = 0;

  // Reference model written from the requirements
  logic [31:0] m_tag [16];
  int          m_cnt [16];
  bit          m_val [16];
  logic [31:0] m_prev;
  bit          m_have;
  int          m_sats;

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] tag;
    int          cnt;
    bit          val;
    string       req;
  } item_t;

  item_t sb[$];

  function automatic int model_hot();
    int best = 0;
    for (int i = 1; i < 16; i++) if (m_cnt[i] > m_cnt[best]) best = i;
    return best;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 1'b0;
      m_cnt[i] = 0;
    end
    m_have = 1'b0;
  endtask

  task automatic model_fetch(input logic [31:0] a);
    int slot;
    if (m_have && a < m_prev) begin
      slot = -1;
      for (int i = 0; i < 16; i++) if (m_val[i] && m_tag[i] == a) slot = i;
      if (slot >= 0) begin
        if (m_cnt[slot] == 255) begin
          for (int i = 0; i < 16; i++) m_cnt[i] = m_cnt[i] / 2;
          m_sats++;
        end
        m_cnt[slot]++;
      end else begin
        for (int i = 15; i >= 0; i--) if (!m_val[i]) slot = i;
        if (slot < 0) begin
          slot = 0;
          for (int i = 1; i < 16; i++) if (m_cnt[i] < m_cnt[slot]) slot = i;
        end
        m_tag[slot] = a;
        m_val[slot] = 1'b1;
        m_cnt[slot] = 1;
      end
    end
    m_prev = a;
    m_have = 1'b1;
  endtask

  // Driver side
  task automatic fetch(input logic [31:0] a);
    @(posedge clk); #1;
    fetch_valid = 1'b1;
    fetch_addr  = a;
    @(posedge clk); #1;
    fetch_valid = 1'b0;
    model_fetch(a);
  endtask

  task automatic idle_addr(input logic [31:0] a);
    @(posedge clk); #1;
    fetch_valid = 1'b0;
    fetch_addr  = a;
  endtask

  task automatic branch_to(input logic [31:0] t);
    fetch(HIGH);
    fetch(t);
  endtask

  task automatic do_clear();
    @(posedge clk); #1;
    clear       = 1'b1;
    fetch_valid = 1'b1;
    fetch_addr  = 32'h4;
    @(posedge clk); #1;
    clear       = 1'b0;
    fetch_valid = 1'b0;
    model_clear();
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic check_entry(input int i, input string req);
    item_t it;
    @(posedge clk); #1;
    rd_idx = 4'(i);
    it.kind = 0; it.idx = i; it.tag = m_tag[i]; it.cnt = m_cnt[i];
    it.val = m_val[i]; it.req = req;
    sb.push_back(it);
    drain();
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) check_entry(i, req);
  endtask

  task automatic check_hot(input string req);
    item_t it;
    @(posedge clk); #1;
    it.kind = 1; it.idx = model_hot(); it.tag = '0; it.cnt = 0;
    it.val = 1'b0; it.req = req;
    sb.push_back(it);
    drain();
  endtask

  // Expected values fixed by the test itself rather than by the model
  task automatic expect_int(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor side
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        it = sb.pop_front();
        total++;
        if (it.kind == 0) begin
          if (rd_valid !== it.val || rd_count !== 8'(it.cnt) || (it.val && rd_tag !== it.tag)) begin
            bad++;
            $display("FAIL %s slot %0d actual v=%0b c=%0d t=%h expected v=%0b c=%0d t=%h",
                     it.req, it.idx, rd_valid, rd_count, rd_tag, it.val, it.cnt, it.tag);
          end
        end else begin
          if (hot_idx !== 4'(it.idx)) begin
            bad++;
            $display("FAIL %s hot_idx actual=%0d expected=%0d", it.req, hot_idx, it.idx);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit first_seen;
    rst_n = 1'b0; clear = 1'b0; fetch_valid = 1'b0; fetch_addr = '0; rd_idx = '0;
    m_sats = 0; m_prev = '0;
    for (int i = 0; i < 16; i++) m_tag[i] = '0;
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R9: empty after reset
    check_entry(0, "R9");
    check_entry(15, "R9");
    check_hot("R9");

    // R1: forward and equal addresses do not count
    fetch(32'h100); fetch(32'h104); fetch(32'h108); fetch(32'h108);
    check_entry(0, "R1");

    // R2: first backward target takes slot 0
    fetch(32'h100);
    check_entry(0, "R2");
    expect_int(rd_count == 8'd1, "R2", rd_count, 1);

    // R1: strobe-low cycles neither count nor record the address
    idle_addr(32'h500);
    idle_addr(32'h10);
    fetch(32'h200);
    check_entry(0, "R1");
    check_entry(1, "R1");

    // R3: hit increments
    fetch(32'h100);
    check_entry(0, "R3");

    // R2: fill remaining slots in order
    for (int i = 1; i < 16; i++) branch_to(32'h200 + 32'(i) * 32'h10);
    check_all("R8");
    check_entry(15, "R2");
    expect_int(rd_tag == 32'h2F0, "R2", rd_tag, 32'h2F0);

    // R3/R6: make slot 1 hottest
    branch_to(32'h210); branch_to(32'h210);
    check_entry(1, "R3");
    check_hot("R6");
    expect_int(hot_idx == 4'd1, "R6", hot_idx, 1);

    // R5: full table, smallest count (slot 2 by lowest index) replaced
    branch_to(32'h800);
    check_all("R5");
    check_entry(2, "R5");
    expect_int(rd_tag == 32'h800 && rd_count == 8'd1, "R5", rd_tag, 32'h800);

    // R7: clear wins over a same-cycle fetch and forgets the old address
    do_clear();
    check_all("R7");
    check_hot("R7");
    fetch(32'h50);
    check_entry(0, "R7");
    fetch(32'h40);
    check_entry(0, "R7");

    // R4/R10: repeated saturation with a 4:1 mix
    do_clear();
    first_seen = 1'b0;
    while (m_sats < 10) begin
      for (int k = 0; k < 4; k++) begin
        branch_to(32'h300);
        if (m_sats == 1 && !first_seen) begin
          first_seen = 1'b1;
          check_entry(0, "R4");
          expect_int(rd_count == 8'd128, "R4", rd_count, 128);
          check_entry(1, "R4");
          check_all("R4");
        end
      end
      branch_to(32'h310);
    end
    check_all("R10");
    check_hot("R10");
    expect_int(hot_idx == 4'd0, "R10", hot_idx, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule